// File: doc/BRIEF.md
# GPIO Interrupt Detect and Route Unit

This unit is the interrupt half of a general-purpose I/O port of up to 32 lines. It takes the already synchronized input vector and, per line, detects either a level or an edge of a programmable polarity. Each detected event is latched into a sticky pending flag. Software clears a flag by writing 1 to its bit. A flag drives an interrupt output only while the line's enable bit is set.

The pending and enabled lines are then routed to a vector of interrupt outputs. A build-time parameter picks one of three routing schemes. In the first, each line drives its own output. In the second, all lines share output 0. In the third, each line reads its output index from its own byte in a set of map words. A simple single-cycle register bus programs the unit and reads it back. Only the lines named by a capability parameter can flag at all. Software finds out which lines these are by writing all ones to the polarity register and reading it back.

Top module: `gpio_irq_route`

## Requirements
- R1: While reset is asserted, the enable, polarity, edge-select, flag and map registers are all zero and every interrupt output is low. With these values every capable line acts as level-low, so its flag sets once reset is released while the line is 0.
- R2: Edge-select bit = 1 selects edge detection by comparing the input with its value one cycle earlier. Polarity 1 flags a rising edge and polarity 0 flags a falling edge. The flag is readable in the cycle after the clock edge that first samples the new input.
- R3: Edge-select bit = 0 selects level detection. The flag sets while the line is at the polarity level, and a set in the same cycle as a clear wins, so a clear written while the level is still active leaves the flag at 1.
- R4: Flags (offset 0x40) are sticky. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R5: The polarity register (offset 0x10) stores and reads back only the bits of capable lines (parameter IRQ_LINES, default 0xFFFF0FFF), and a line that is not capable never sets its flag.
- R6: The enable register (offset 0x0C) gates only the outputs: a flag whose enable bit is 0 still records, but contributes to no interrupt output.
- R7: The capability word at offset 0x18 is read-only. Bits 20:16 hold the routing code (0 per-line, 1 shared, 2 mapped), and all other bits read 0.
- R8: In per-line routing, output n is the flag AND enable of line n.
- R9: In shared routing, output 0 is the OR over all lines of flag AND enable, and every other output stays 0.
- R10: In mapped routing, the map word at offset 0x20 + 4·w (w = n/4) serves line n. The line's byte starts at bit 8·(3 − n mod 4), and the low 5 bits of that byte give its output index. Output k is the OR of flag AND enable over the lines whose index is k. Map words read back all 32 bits as written.
- R11: Edge-select (offset 0x14) reads back as written. Reading an unused offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | N_LINES | Synchronized input line levels |
| bus_we_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | IRQ_W | Interrupt output vector |

## Verification
The bound checker checks on every cycle the properties that hold whatever the stimulus:
- the register values during reset;
- that a flag never drops without a write-one-to-clear of its bit;
- that lines which are not capable never flag;
- that outputs stay low when no enabled flag is pending;
- in shared routing, that only output 0 is ever driven.

The polarity and edge selection, the set-wins rule in level mode, and the byte-lane placement of the map index can only be shown by the bench's scenarios. The bench runs three copies of the unit, one per routing mode, on the same stimulus and compares their outputs with expected values worked out by hand.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;
  localparam logic [BUS_AW-1:0] OFF_ENABLE = 8'h0C;
  localparam logic [BUS_AW-1:0] OFF_POL    = 8'h10;
  localparam logic [BUS_AW-1:0] OFF_EDGE   = 8'h14;
  localparam logic [BUS_AW-1:0] OFF_CAP    = 8'h18;
  localparam logic [BUS_AW-1:0] OFF_MAP    = 8'h20;
  localparam logic [BUS_AW-1:0] OFF_FLAG   = 8'h40;
  localparam int ROUTE_OWN    = 0;
  localparam int ROUTE_SHARED = 1;
  localparam int ROUTE_MAP    = 2;
  localparam int IDX_W = 5;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter logic [31:0] IRQ_LINES = 32'hFFFF_0FFF,
  parameter int ROUTE_MODE = ROUTE_MAP,
  localparam int N_WORDS = N_LINES / 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [BUS_AW-1:0]                addr_i,
  input  logic [BUS_DW-1:0]                wdata_i,
  input  logic [N_LINES-1:0]               flag_i,
  output logic [N_LINES-1:0]               enable_o,
  output logic [N_LINES-1:0]               pol_o,
  output logic [N_LINES-1:0]               edge_o,
  output logic [N_WORDS-1:0][BUS_DW-1:0]   map_o,
  output logic [N_LINES-1:0]               clr_o,
  output logic [BUS_DW-1:0]                rdata_o
);
  localparam logic [N_LINES-1:0] CAP_MASK = IRQ_LINES[N_LINES-1:0];
  localparam logic [BUS_DW-1:0] CAP_WORD = {11'd0, IDX_W'(ROUTE_MODE), 16'd0};

  logic [BUS_AW-1:0] map_off;
  logic              map_hit;

  assign map_off = addr_i - OFF_MAP;
  assign map_hit = (addr_i >= OFF_MAP) && (map_off[1:0] == 2'b00)
                   && ({26'd0, map_off[7:2]} < 32'(N_WORDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_o <= '0;
      pol_o    <= '0;
      edge_o   <= '0;
      map_o    <= '0;
    end else if (we_i) begin
      if (addr_i == OFF_ENABLE) enable_o <= wdata_i[N_LINES-1:0];
      if (addr_i == OFF_POL)    pol_o    <= wdata_i[N_LINES-1:0] & CAP_MASK;
      if (addr_i == OFF_EDGE)   edge_o   <= wdata_i[N_LINES-1:0];
      for (int w = 0; w < N_WORDS; w++)
        if (map_hit && map_off[7:2] == 6'(w)) map_o[w] <= wdata_i;
    end
  end

  assign clr_o = (we_i && addr_i == OFF_FLAG) ? wdata_i[N_LINES-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_ENABLE: rdata_o = BUS_DW'(enable_o);
      OFF_POL:    rdata_o = BUS_DW'(pol_o);
      OFF_EDGE:   rdata_o = BUS_DW'(edge_o);
      OFF_CAP:    rdata_o = CAP_WORD;
      OFF_FLAG:   rdata_o = BUS_DW'(flag_i);
      default: begin
        for (int w = 0; w < N_WORDS; w++)
          if (map_hit && map_off[7:2] == 6'(w)) rdata_o = map_o[w];
      end
    endcase
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N_LINES = 32,
  parameter logic [31:0] IRQ_LINES = 32'hFFFF_0FFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  input  logic [N_LINES-1:0] pol_i,
  input  logic [N_LINES-1:0] edge_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] flag_o
);
  localparam logic [N_LINES-1:0] CAP_MASK = IRQ_LINES[N_LINES-1:0];

  logic [N_LINES-1:0] prev_q, rise, fall, lvl_hit, edg_hit, hit;

  assign rise    = line_i & ~prev_q;
  assign fall    = ~line_i & prev_q;
  assign edg_hit = (pol_i & rise) | (~pol_i & fall);
  assign lvl_hit = (pol_i & line_i) | (~pol_i & ~line_i);
  assign hit     = CAP_MASK & ((edge_i & edg_hit) | (~edge_i & lvl_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_o <= '0;
    end else begin
      prev_q <= line_i;
      flag_o <= (flag_o & ~clr_i) | hit;  // set wins over clear
    end
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int IRQ_W = 32,
  parameter int ROUTE_MODE = ROUTE_MAP,
  localparam int N_WORDS = N_LINES / 4
) (
  input  logic [N_LINES-1:0]             pend_i,
  input  logic [N_WORDS-1:0][BUS_DW-1:0] map_i,
  output logic [IRQ_W-1:0]               irq_o
);
  logic unused_map;
  assign unused_map = ^map_i;

  if (ROUTE_MODE == ROUTE_OWN) begin : g_own
    for (genvar k = 0; k < IRQ_W; k++) begin : g_out
      if (k < N_LINES) begin : g_on
        assign irq_o[k] = pend_i[k];
      end else begin : g_off
        assign irq_o[k] = 1'b0;
      end
    end
  end else if (ROUTE_MODE == ROUTE_SHARED) begin : g_shared
    assign irq_o = IRQ_W'(|pend_i);
  end else begin : g_map
    logic [N_LINES-1:0][IDX_W-1:0] idx;
    for (genvar n = 0; n < N_LINES; n++) begin : g_idx
      assign idx[n] = map_i[n/4][(3 - n%4)*8 +: IDX_W];
    end
    always_comb begin
      irq_o = '0;
      for (int k = 0; k < IRQ_W; k++)
        for (int n = 0; n < N_LINES; n++)
          if (pend_i[n] && idx[n] == IDX_W'(k)) irq_o[k] = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int IRQ_W = 32,
  parameter int ROUTE_MODE = ROUTE_MAP,
  parameter logic [31:0] IRQ_LINES = 32'hFFFF_0FFF,
  localparam int N_WORDS = N_LINES / 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  input  logic               bus_we_i,
  input  logic [BUS_AW-1:0]  bus_addr_i,
  input  logic [BUS_DW-1:0]  bus_wdata_i,
  output logic [BUS_DW-1:0]  bus_rdata_o,
  output logic [IRQ_W-1:0]   irq_o
);
  logic [N_LINES-1:0] enable_q, pol_q, edge_q, clr, flag_q, pend;
  logic [N_WORDS-1:0][BUS_DW-1:0] map_q;

  gpio_irq_regs #(
    .N_LINES(N_LINES), .IRQ_LINES(IRQ_LINES), .ROUTE_MODE(ROUTE_MODE)
  ) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .flag_i(flag_q), .enable_o(enable_q), .pol_o(pol_q),
    .edge_o(edge_q), .map_o(map_q), .clr_o(clr), .rdata_o(bus_rdata_o)
  );

  gpio_irq_detect #(.N_LINES(N_LINES), .IRQ_LINES(IRQ_LINES)) i_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .pol_i(pol_q),
    .edge_i(edge_q), .clr_i(clr), .flag_o(flag_q)
  );

  assign pend = flag_q & enable_q;

  gpio_irq_router #(
    .N_LINES(N_LINES), .IRQ_W(IRQ_W), .ROUTE_MODE(ROUTE_MODE)
  ) i_router (
    .pend_i(pend), .map_i(map_q), .irq_o(irq_o)
  );
endmodule

// File: rtl/gpio_irq_route_chk.sv
module gpio_irq_route_chk
  import gpio_irq_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int IRQ_W = 32,
  parameter int ROUTE_MODE = ROUTE_MAP,
  parameter logic [31:0] IRQ_LINES = 32'hFFFF_0FFF
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_we_i,
  input logic [BUS_AW-1:0]  bus_addr_i,
  input logic [BUS_DW-1:0]  bus_wdata_i,
  input logic [N_LINES-1:0] flag_i,
  input logic [N_LINES-1:0] enable_i,
  input logic [IRQ_W-1:0]   irq_o
);
  logic [N_LINES-1:0] wr_clr;
  assign wr_clr = (bus_we_i && bus_addr_i == OFF_FLAG) ? bus_wdata_i[N_LINES-1:0] : '0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      // R1
      reset_state_chk: assert (flag_i == '0 && enable_i == '0 && irq_o == '0);
    end
  end

  // R4
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(flag_i) & ~$past(wr_clr)) & ~flag_i) == '0));

  // R5
  incapable_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i & ~IRQ_LINES[N_LINES-1:0]) == '0);

  // R6
  gated_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_i & enable_i) == '0) |-> (irq_o == '0));

  if (ROUTE_MODE == ROUTE_SHARED) begin : g_shared
    // R9
    shared_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((irq_o >> 1) == '0) && (irq_o[0] == |(flag_i & enable_i)));
  end
endmodule

bind gpio_irq_route gpio_irq_route_chk #(
  .N_LINES(N_LINES), .IRQ_W(IRQ_W), .ROUTE_MODE(ROUTE_MODE), .IRQ_LINES(IRQ_LINES)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .flag_i(flag_q), .enable_i(enable_q), .irq_o(irq_o)
);

// File: tb/test_gpio_irq_route.sv
module test_gpio_irq_route;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] line = '0;
  logic we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_m, rd_o, rd_s, irq_m, irq_o, irq_s;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_irq_route #(.ROUTE_MODE(2)) i_gpio_irq_route (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rd_m), .irq_o(irq_m));
  gpio_irq_route #(.ROUTE_MODE(0)) i_gpio_irq_route_own (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rd_o), .irq_o(irq_o));
  gpio_irq_route #(.ROUTE_MODE(1)) i_gpio_irq_route_shr (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rd_s), .irq_o(irq_s));

  // {line value, expected flags} in rising-edge mode, all enabled
  localparam logic [63:0] VEC [4] = '{
    {32'h0000_0001, 32'h0000_0001},
    {32'h0000_0000, 32'h0000_0001},
    {32'h0000_F00F, 32'h0000_000F},
    {32'hFFFF_FFFF, 32'hFFFF_0FFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic look(input logic [7:0] a);
    addr = a;
    #1;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    line = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    look(8'h40); chk("R1 flag in reset", rd_m, 32'h0);
    look(8'h0C); chk("R1 enable in reset", rd_m, 32'h0);
    look(8'h24); chk("R1 map in reset", rd_m, 32'h0);
    chk("R1 irq in reset", irq_m | irq_o | irq_s, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    look(8'h40); chk("R3 level-low default flags", rd_m, 32'hFFFF_0FFF);
    chk("R6 flags pending but disabled", irq_m | irq_o | irq_s, 32'h0);
    look(8'h18);
    chk("R7 cap map", rd_m, 32'h0002_0000);
    chk("R7 cap own", rd_o, 32'h0000_0000);
    chk("R7 cap shared", rd_s, 32'h0001_0000);
    wr(8'h18, 32'hFFFF_FFFF);
    look(8'h18); chk("R7 cap read-only", rd_m, 32'h0002_0000);

    wr(8'h10, 32'hFFFF_FFFF);
    look(8'h10); chk("R5 capable lines", rd_m, 32'hFFFF_0FFF);
    wr(8'h14, 32'hFFFF_FFFF);
    look(8'h14); chk("R11 edge readback", rd_m, 32'hFFFF_FFFF);
    look(8'h44); chk("R11 unused offset", rd_m, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    look(8'h40); chk("R4 clear all", rd_m, 32'h0);

    for (int i = 0; i < 4; i++) begin
      drive(VEC[i][63:32]);
      look(8'h40); chk("R2 rising edge flags", rd_m, VEC[i][31:0]);
      chk("R8 own routing", irq_o, VEC[i][31:0]);
      chk("R9 shared routing", irq_s, {31'd0, |VEC[i][31:0]});
      chk("R5 incapable never flag", rd_m & 32'h0000_F000, 32'h0);
    end

    wr(8'h40, 32'h0000_0003);
    look(8'h40); chk("R4 w1c clears ones", rd_m, 32'hFFFF_0FFC);
    wr(8'h40, 32'h0000_0000);
    look(8'h40); chk("R4 zero write no effect", rd_m, 32'hFFFF_0FFC);
    wr(8'h40, 32'hFFFF_FFFF);

    wr(8'h10, 32'hFFFF_FFFE);
    drive(32'hFFFF_FFFE);
    look(8'h40); chk("R2 falling edge line0", rd_m, 32'h0000_0001);

    wr(8'h14, 32'hFFFF_FFFD);
    repeat (2) @(negedge clk);
    look(8'h40); chk("R3 level high sets", rd_m, 32'h0000_0003);
    wr(8'h40, 32'h0000_0002);
    look(8'h40); chk("R3 set wins over clear", rd_m, 32'h0000_0003);
    drive(32'hFFFF_FFFC);
    look(8'h40); chk("R4 sticky after level drop", rd_m, 32'h0000_0003);
    wr(8'h40, 32'h0000_0002);
    look(8'h40); chk("R3 clear after level drop", rd_m, 32'h0000_0001);

    wr(8'h0C, 32'hFFFF_FFFE);
    look(8'h40); chk("R6 flag kept while disabled", rd_m, 32'h0000_0001);
    chk("R6 disabled irq", irq_m | irq_o | irq_s, 32'h0);

    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    drive(32'h0000_0000);
    wr(8'h40, 32'hFFFF_FFFF);
    look(8'h40); chk("R4 cleared before map test", rd_m, 32'h0);

    wr(8'h20, 32'h0500_0000);
    wr(8'h24, 32'h0000_1F00);
    wr(8'h3C, 32'h0000_00E7);
    look(8'h3C); chk("R10 map readback", rd_m, 32'h0000_00E7);
    drive(32'h0000_0001);
    chk("R10 line0 to output 5", irq_m, 32'h0000_0020);
    chk("R8 line0 own", irq_o, 32'h0000_0001);
    drive(32'h8000_0041);
    chk("R10 lines 0/6/31 to 5/31/7", irq_m, 32'h8000_00A0);
    wr(8'h40, 32'h0000_0001);
    chk("R10 after clear line0", irq_m, 32'h8000_0080);
    chk("R9 shared still set", irq_s, 32'h0000_0001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule